// File: doc/BRIEF.md
# Handshaked External Peripheral Bus Master

This block sits between a processor core and a small field of external peripheral registers. The core hands it a single request: a slot address, a read/write flag and, for a write, a data word. The block then runs one framed access on an external bus of eight 16-bit register slots. That bus has a 3-bit address, an active-low data strobe, a direction line and a 16-bit data path that is split into an input half, an output half and an output enable, so the pad ring can build the tristate driver.

An access always follows the same order of clock cycles. A setup cycle puts the address and direction on the bus with the strobe still high. One or more strobe cycles follow with the strobe low. A hold cycle comes last, with the strobe back high and the address, direction and write data still held. A WAIT input stretches the strobe phase by one cycle for each clock edge at which it is found high. Read data is taken from the bus at the edge where the strobe rises. A one-cycle done pulse tells the core that the access is complete.

The controller is a four-state machine:
- `ST_IDLE` moves to `ST_SETUP` when a request is seen.
- `ST_SETUP` always moves to `ST_STROBE`.
- `ST_STROBE` loops on itself while WAIT is high and moves to `ST_HOLD` when WAIT is low.
- `ST_HOLD` always moves back to `ST_IDLE`.

Top module: `xbus_master`

## Requirements
- R1: While reset is asserted, and in the idle state, the strobe output is high, the direction output is high, the address output is zero, the bus output enable is low and done is low.
- R2: A request is taken only in the idle state. Request, address, flag and write-data inputs that change during an access have no effect on that access, and no second access starts unless a request is present in the idle state.
- R3: The address and direction of an access appear on the bus one full cycle (the setup cycle) before the strobe goes low, with the strobe high in that cycle.
- R4: With WAIT low at the first strobe cycle's closing edge, the strobe is low for exactly one cycle.
- R5: Each rising clock edge during the strobe phase at which WAIT is high keeps the strobe low for one more cycle. WAIT has no effect in the setup, hold or idle cycles.
- R6: In the cycle after the strobe rises (the hold cycle), the address, direction and driven write data are unchanged from the strobe phase.
- R7: The direction output is 1 for a read and 0 for a write throughout setup, strobe and hold. The core flag `rd_i` uses the same encoding: 1 = read, 0 = write.
- R8: The bus output enable is high in the setup, strobe and hold cycles of a write, with the write data on `bus_d_o`. It is low during reads and between accesses.
- R9: For a read, `rdata_o` takes the value on `bus_d_i` at the clock edge where the strobe rises and keeps it until the next read. Writes leave `rdata_o` unchanged.
- R10: `done_o` is high for exactly one cycle per access: the hold cycle, just after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request, sampled in idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 3 | Register slot address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Last read data |
| done_o | output | 1 | One-cycle completion pulse |
| ext_addr_o | output | 3 | External slot address |
| strobe_n_o | output | 1 | Data strobe, active low |
| dir_rd_o | output | 1 | External direction, 1 = read |
| bus_d_o | output | 16 | Data driven onto the bus |
| bus_oe_o | output | 1 | Output enable for the data driver |
| bus_d_i | input | 16 | Data read from the bus |
| wait_i | input | 1 | Stretch request from the peripheral |

## Verification
The bench varies the WAIT count from zero to several cycles and puts a new value on the data bus in every strobe cycle. A design that samples read data one edge early or late would therefore return the wrong word, and one that miscounts WAIT would raise the strobe at the wrong cycle. It also holds WAIT high through the setup and hold cycles, where a design that samples WAIT outside the strobe phase would stretch the wrong phase. During accesses it changes the core inputs and keeps the request high, which catches a master that reads its inputs live or starts a second access. A write placed between two reads shows whether the read register is overwritten.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } xbus_state_e;

endpackage

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        wait_i,
    output xbus_state_e state_o,
    output logic        accept_o,
    output logic        capture_o
);

    xbus_state_e state_q;
    xbus_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        accept_o  = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_SETUP;
                end
            end
            ST_SETUP: begin
                state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (!wait_i) begin
                    capture_o = 1'b1;
                    state_d   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          capture_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    input  logic [DW-1:0] bus_d_i,
    output logic [AW-1:0] lat_addr_o,
    output logic [DW-1:0] lat_wdata_o,
    output logic          lat_rd_o,
    output logic [DW-1:0] rdata_o
);

    // request latch: frozen for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr_o  <= '0;
            lat_wdata_o <= '0;
            lat_rd_o    <= 1'b1;
        end else if (accept_i) begin
            lat_addr_o  <= addr_i;
            lat_wdata_o <= wdata_i;
            lat_rd_o    <= rd_i;
        end
    end

    // read data register: loaded at the strobe-rising edge of reads only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (capture_i && lat_rd_o) begin
            rdata_o <= bus_d_i;
        end
    end

endmodule

// File: rtl/xbus_master.sv
module xbus_master
    import xbus_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic [AW-1:0] ext_addr_o,
    output logic          strobe_n_o,
    output logic          dir_rd_o,
    output logic [DW-1:0] bus_d_o,
    output logic          bus_oe_o,
    input  logic [DW-1:0] bus_d_i,
    input  logic          wait_i
);

    xbus_state_e   state;
    logic          accept;
    logic          capture;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          lat_rd;

    xbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .wait_i    (wait_i),
        .state_o   (state),
        .accept_o  (accept),
        .capture_o (capture)
    );

    xbus_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .capture_i   (capture),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .rd_i        (rd_i),
        .bus_d_i     (bus_d_i),
        .lat_addr_o  (lat_addr),
        .lat_wdata_o (lat_wdata),
        .lat_rd_o    (lat_rd),
        .rdata_o     (rdata_o)
    );

    // output decode from state and latched request
    always_comb begin
        ext_addr_o = '0;
        strobe_n_o = 1'b1;
        dir_rd_o   = 1'b1;
        bus_oe_o   = 1'b0;
        done_o     = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_SETUP: begin
                ext_addr_o = lat_addr;
                dir_rd_o   = lat_rd;
                bus_oe_o   = !lat_rd;
            end
            ST_STROBE: begin
                ext_addr_o = lat_addr;
                dir_rd_o   = lat_rd;
                bus_oe_o   = !lat_rd;
                strobe_n_o = 1'b0;
            end
            ST_HOLD: begin
                ext_addr_o = lat_addr;
                dir_rd_o   = lat_rd;
                bus_oe_o   = !lat_rd;
                done_o     = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign bus_d_o = bus_oe_o ? lat_wdata : '0;

endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk #(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] rdata_o,
    input logic          done_o,
    input logic [AW-1:0] ext_addr_o,
    input logic          strobe_n_o,
    input logic          dir_rd_o,
    input logic          bus_oe_o,
    input logic [DW-1:0] bus_d_i,
    input logic          wait_i
);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (strobe_n_o && dir_rd_o && !bus_oe_o && !done_o && ext_addr_o == '0);
        end
    end

    assert_addr_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n_o) |-> $stable(ext_addr_o) && $stable(dir_rd_o));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strobe_n_o) && !wait_i) |=> strobe_n_o);

    assert_wait_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_o && wait_i) |=> !strobe_n_o);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n_o) |-> $stable(ext_addr_o) && $stable(dir_rd_o) && $stable(bus_oe_o));

    assert_oe_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> !dir_rd_o);

    assert_read_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_n_o) && dir_rd_o) |-> rdata_o == $past(bus_d_i));

    assert_done_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_place_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> strobe_n_o && $past(!strobe_n_o));

endmodule

bind xbus_master xbus_master_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdata_o    (rdata_o),
    .done_o     (done_o),
    .ext_addr_o (ext_addr_o),
    .strobe_n_o (strobe_n_o),
    .dir_rd_o   (dir_rd_o),
    .bus_oe_o   (bus_oe_o),
    .bus_d_i    (bus_d_i),
    .wait_i     (wait_i)
);

// File: tb/xbus_master_tb.sv
module xbus_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        rd_i = 1'b1;
    logic [2:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        done_o;
    logic [2:0]  ext_addr_o;
    logic        strobe_n_o;
    logic        dir_rd_o;
    logic [15:0] bus_d_o;
    logic        bus_oe_o;
    logic [15:0] bus_d_i = '0;
    logic        wait_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_rdata = '0;

    always #10 clk = ~clk;

    xbus_master u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .rd_i       (rd_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .done_o     (done_o),
        .ext_addr_o (ext_addr_o),
        .strobe_n_o (strobe_n_o),
        .dir_rd_o   (dir_rd_o),
        .bus_d_o    (bus_d_o),
        .bus_oe_o   (bus_oe_o),
        .bus_d_i    (bus_d_i),
        .wait_i     (wait_i)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every output against the expected bus cycle
    task automatic expect_cycle(input string tag, input logic stb, input logic [2:0] a, input logic dir,
                                input logic oe, input logic [15:0] d, input logic dn);
        chk(tag, "strobe_n", {15'd0, strobe_n_o}, {15'd0, stb});
        chk((tag == "R1") ? "R1" : "R3", "ext_addr", {13'd0, ext_addr_o}, {13'd0, a});
        chk((tag == "R1") ? "R1" : "R7", "dir_rd", {15'd0, dir_rd_o}, {15'd0, dir});
        chk((tag == "R1") ? "R1" : "R8", "bus_oe", {15'd0, bus_oe_o}, {15'd0, oe});
        if (oe) chk("R8", "bus_d_o", bus_d_o, d);
        chk((tag == "R1") ? "R1" : "R10", "done", {15'd0, done_o}, {15'd0, dn});
        chk("R9", "rdata", rdata_o, model_rdata);
    endtask

    // one access, called at a falling edge; returns at the falling edge of the idle cycle after it
    task automatic access(input bit rd, input logic [2:0] a, input logic [15:0] wd, input int nw,
                          input logic [15:0] rv, input bit noise, input bit holdreq);
        req_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = wd; wait_i = noise; bus_d_i = 16'hDEAD;
        @(negedge clk);
        // setup cycle
        expect_cycle("R3", 1'b1, a, rd, !rd, wd, 1'b0);
        if (!holdreq) req_i = 1'b0;
        addr_i = ~a; wdata_i = ~wd; rd_i = ~rd;   // R2: live inputs must not leak in
        for (int k = 0; k <= nw; k++) begin
            @(negedge clk);
            expect_cycle((k == 0) ? "R4" : "R5", 1'b0, a, rd, !rd, wd, 1'b0);
            wait_i  = (k < nw);
            bus_d_i = (k == nw) ? rv : (16'h5A00 + 16'(k));
        end
        @(negedge clk);
        // hold cycle
        if (rd) model_rdata = rv;
        expect_cycle("R6", 1'b1, a, rd, !rd, wd, 1'b1);
        wait_i = noise; req_i = 1'b0; bus_d_i = 16'hBEEF;
        @(negedge clk);
        // back to idle, no second access
        expect_cycle("R2", 1'b1, 3'd0, 1'b1, 1'b0, 16'd0, 1'b0);
        wait_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_cycle("R1", 1'b1, 3'd0, 1'b1, 1'b0, 16'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_cycle("R1", 1'b1, 3'd0, 1'b1, 1'b0, 16'd0, 1'b0);
        access(1'b0, 3'd5, 16'hA5C3, 0, 16'h0000, 1'b0, 1'b0);   // R4 write, no wait
        access(1'b1, 3'd7, 16'h0000, 0, 16'h1234, 1'b0, 1'b0);   // R9 read, no wait
        access(1'b1, 3'd0, 16'h0000, 3, 16'hCAFE, 1'b0, 1'b0);   // R5 read, three waits
        access(1'b0, 3'd2, 16'h0F0F, 2, 16'h0000, 1'b1, 1'b0);   // R5 write, WAIT noise outside strobe; R9 rdata kept
        access(1'b1, 3'd3, 16'h0000, 1, 16'h8001, 1'b1, 1'b1);   // R2 request held high
        access(1'b0, 3'd6, 16'hFFFF, 5, 16'h0000, 1'b0, 1'b1);   // R2 write with long stretch
        // R2: idle with no request, WAIT toggling, stays idle
        wait_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            expect_cycle("R2", 1'b1, 3'd0, 1'b1, 1'b0, 16'd0, 1'b0);
        end
        wait_i = 1'b0;
        access(1'b1, 3'd1, 16'h0000, 0, 16'h7E57, 1'b0, 1'b0);   // R9 back-to-back read
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule